// File: doc/BRIEF.md
# Dual Programmable Interval Timer

This block holds two independent 32-bit up-counters that a processor core reads and writes through its auxiliary register port. Each timer has a count, a limit and a two-bit control word. The counter advances by one on each clock. When it equals its limit it returns to zero on the next cycle. If the timer's interrupt enable is set, reaching the limit also sets a sticky pending flag, which drives that timer's interrupt line.

Software has three controls over each timer. It can restart a timer by writing its count. It can acknowledge an interrupt by writing anything to the control register. It can set a gating bit so that the counter stops while the core reports itself halted. If the limit is left at all ones and the interrupt enable is left clear, the timer is a free-running wrapping counter, suitable as a time base. Reads are combinational from the address.

Top module: `dtimer_top`

## Requirements
- R1: Synchronous active-high reset gives both counts the value 0 and both control words the value 0, sets both limits to 0xFFFFFFFF, and holds both interrupt lines low.
- R2: Timer 0 count, control and limit are at auxiliary addresses 0x021, 0x022 and 0x023. Timer 1 count, control and limit are at 0x100, 0x101 and 0x102. A control read returns bit 0 (interrupt enable) and bit 1 (halt gating) with bits 31:2 as zero.
- R3: While advancing, a count that is below its limit increments by one per clock. A count equal to its limit becomes 0 on the next clock.
- R4: When bit 0 of control is set and the count reaches its limit on an advancing clock, the timer's interrupt line is high from the next cycle. It stays high until a control write.
- R5: Any write to a control register, whatever its data, drives that timer's interrupt line low from the next cycle. This holds even if a limit hit occurs in the same cycle.
- R6: With bit 1 of control set, the count holds while core_halted is high. With bit 1 clear, the count advances every clock regardless of core_halted.
- R7: A count write loads the written value on the next cycle and takes priority over an increment or wrap in the same cycle. A limit hit in that cycle is discarded and raises no interrupt.
- R8: A read from any address outside the six mapped ones returns zero. A write to such an address changes no timer state.
- R9: The two timers are independent. Writes, limit hits and acknowledges on one timer never affect the registers or interrupt line of the other.
- R10: With limit 0xFFFFFFFF and bit 0 of control clear, the count runs through 0xFFFFFFFF to 0 and the interrupt line stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| core_halted | input | 1 | High while the core is halted; gates counting when a timer's bit 1 is set |
| aux_wr | input | 1 | Write strobe for the auxiliary port |
| aux_addr | input | 12 | Auxiliary register address, used for both read and write |
| aux_wdata | input | DATA_W (32) | Write data |
| aux_rdata | output | DATA_W (32) | Combinational read data for aux_addr |
| tmr_irq | output | 2 | Interrupt lines; bit i belongs to timer i |

## Verification
The bench probes four corner cases.

- **Control write on the limit cycle.** The control write lands in the exact cycle the count hits its limit. A design that lets the hit win would leave the interrupt line high after the acknowledge.
- **Count write on the limit cycle.** A count write races a wrap. A design that gives the increment priority would load 0 or count+1 instead of the written value, or raise a stray interrupt.
- **Gating while halted.** With gating set and the halt input high, a design that ignores the gate keeps counting. With gating clear, a design that always gates would stall.
- **Free-running wrap and decode.** The bench steps through the all-ones to zero wrap with interrupts off. It then issues writes to addresses next to the mapped ones. A decode that is off by one would corrupt a neighbouring timer or return nonzero data.

// File: rtl/dtimer_pkg.sv
package dtimer_pkg;

    localparam int NTMR   = 2;
    localparam int AUX_AW = 12;
    localparam int CTRL_W = 2;
    localparam int NREG   = 3;

    // Base address of each timer; count, control, limit follow at +0, +1, +2.
    localparam logic [NTMR-1:0][AUX_AW-1:0] TMR_BASE = {12'h100, 12'h021};

    typedef enum logic [1:0] {
        OFS_CNT = 2'd0,
        OFS_CTL = 2'd1,
        OFS_LIM = 2'd2
    } reg_ofs_e;

    typedef struct packed {
        logic halt_gate;   // bit 1
        logic irq_en;      // bit 0
    } tmr_ctrl_t;

    typedef struct packed {
        logic cnt;
        logic ctl;
        logic lim;
    } reg_sel_t;

    function automatic logic addr_is(input logic [AUX_AW-1:0] a,
                                     input logic [AUX_AW-1:0] base,
                                     input reg_ofs_e ofs);
        return a == (base + AUX_AW'(ofs));
    endfunction

    function automatic reg_sel_t decode_one(input logic [AUX_AW-1:0] a,
                                            input logic [AUX_AW-1:0] base);
        reg_sel_t s;
        s.cnt = addr_is(a, base, OFS_CNT);
        s.ctl = addr_is(a, base, OFS_CTL);
        s.lim = addr_is(a, base, OFS_LIM);
        return s;
    endfunction

endpackage

// File: rtl/dtimer_decode.sv
module dtimer_decode
    import dtimer_pkg::*;
(
    input  logic [AUX_AW-1:0]      addr,
    input  logic                   wr,
    output reg_sel_t [NTMR-1:0]    rsel,
    output reg_sel_t [NTMR-1:0]    wsel,
    output logic                   mapped
);

    for (genvar i = 0; i < NTMR; i++) begin : g_dec
        assign rsel[i] = decode_one(addr, TMR_BASE[i]);
        assign wsel[i] = wr ? rsel[i] : '0;
    end

    assign mapped = |rsel;

    // R2: at most one register is selected for any address
    always_comb begin
        if (!$isunknown(addr)) begin
            p_sel_onehot_r2: assert ($onehot0(rsel));
        end
    end

endmodule

// File: rtl/dtimer_chan.sv
module dtimer_chan
    import dtimer_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              halted,
    input  logic [DATA_W-1:0] wdata,
    input  reg_sel_t          wsel,
    input  reg_sel_t          rsel,
    output logic [DATA_W-1:0] rdata,
    output logic              irq
);

    localparam logic [DATA_W-1:0] ONE      = DATA_W'(1);
    localparam logic [DATA_W-1:0] LIM_INIT = '1;

    logic [DATA_W-1:0] count;
    logic [DATA_W-1:0] limit;
    tmr_ctrl_t         ctrl;
    logic              pending;

    logic advance;
    logic hit;

    assign advance = !ctrl.halt_gate || !halted;
    assign hit     = advance && !wsel.cnt && (count == limit);

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (wsel.cnt) begin
            count <= wdata;
        end else if (advance) begin
            count <= hit ? '0 : count + ONE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            limit <= LIM_INIT;
            ctrl  <= '0;
        end else begin
            if (wsel.lim) limit <= wdata;
            if (wsel.ctl) ctrl  <= tmr_ctrl_t'(wdata[CTRL_W-1:0]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pending <= 1'b0;
        end else if (wsel.ctl) begin
            pending <= 1'b0;
        end else if (hit && ctrl.irq_en) begin
            pending <= 1'b1;
        end
    end

    assign irq = pending;

    always_comb begin
        rdata = '0;
        if (rsel.cnt) rdata = count;
        if (rsel.ctl) rdata = {{(DATA_W-CTRL_W){1'b0}}, ctrl};
        if (rsel.lim) rdata = limit;
    end

    // R3: wrap to zero after the limit is reached
    p_wrap_r3: assert property (@(posedge clk) disable iff (rst)
        hit |=> count == '0);

    // R4: enabled hit raises the interrupt line
    p_irq_set_r4: assert property (@(posedge clk) disable iff (rst)
        (hit && ctrl.irq_en && !wsel.ctl) |=> irq);

    // R4: interrupt stays up until a control write
    p_irq_sticky_r4: assert property (@(posedge clk) disable iff (rst)
        (irq && !wsel.ctl) |=> irq);

    // R5: any control write acknowledges
    p_ack_r5: assert property (@(posedge clk) disable iff (rst)
        wsel.ctl |=> !irq);

    // R6: gated counter holds while halted
    p_halt_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (ctrl.halt_gate && halted && !wsel.cnt) |=> $stable(count));

    // R6: ungated counter advances below the limit
    p_run_r6: assert property (@(posedge clk) disable iff (rst)
        (!ctrl.halt_gate && !wsel.cnt && count != limit) |=> count == $past(count) + ONE);

    // R7: count write wins over increment
    p_cnt_wr_r7: assert property (@(posedge clk) disable iff (rst)
        wsel.cnt |=> count == $past(wdata));

    // R10: no interrupt appears while disabled
    p_no_irq_r10: assert property (@(posedge clk) disable iff (rst)
        (!ctrl.irq_en && !irq) |=> !irq);

endmodule

// File: rtl/dtimer_top.sv
module dtimer_top
    import dtimer_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              core_halted,
    input  logic              aux_wr,
    input  logic [AUX_AW-1:0] aux_addr,
    input  logic [DATA_W-1:0] aux_wdata,
    output logic [DATA_W-1:0] aux_rdata,
    output logic [NTMR-1:0]   tmr_irq
);

    reg_sel_t [NTMR-1:0] rsel;
    reg_sel_t [NTMR-1:0] wsel;
    logic                mapped;
    logic [DATA_W-1:0]   rd_part [NTMR];

    dtimer_decode u_dec (
        .addr   (aux_addr),
        .wr     (aux_wr),
        .rsel   (rsel),
        .wsel   (wsel),
        .mapped (mapped)
    );

    for (genvar i = 0; i < NTMR; i++) begin : g_tmr
        dtimer_chan #(.DATA_W(DATA_W)) u_chan (
            .clk    (clk),
            .rst    (rst),
            .halted (core_halted),
            .wdata  (aux_wdata),
            .wsel   (wsel[i]),
            .rsel   (rsel[i]),
            .rdata  (rd_part[i]),
            .irq    (tmr_irq[i])
        );
    end

    always_comb begin
        aux_rdata = '0;
        for (int i = 0; i < NTMR; i++) begin
            aux_rdata = aux_rdata | rd_part[i];
        end
    end

    // R8: unmapped addresses read as zero
    p_unmapped_r8: assert property (@(posedge clk) disable iff (rst)
        !mapped |-> aux_rdata == '0);

    // R1: interrupt lines are low in the first cycle after reset
    p_reset_irq_r1: assert property (@(posedge clk)
        rst |=> tmr_irq == '0);

endmodule

// File: tb/dtimer_top_test.sv
`timescale 1ns/1ps
module dtimer_top_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        halted = 1'b0;
    logic        wr = 1'b0;
    logic [11:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [1:0]  irq;

    always #2.5 clk = ~clk;

    dtimer_top uut (
        .clk         (clk),
        .rst         (rst),
        .core_halted (halted),
        .aux_wr      (wr),
        .aux_addr    (addr),
        .aux_wdata   (wdata),
        .aux_rdata   (rdata),
        .tmr_irq     (irq)
    );

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    logic [31:0] m_cnt  [2];
    logic [31:0] m_lim  [2];
    logic [1:0]  m_ctl  [2];
    logic        m_pend [2];

    function automatic logic [11:0] base_of(input int t);
        return (t == 0) ? 12'h021 : 12'h100;
    endfunction

    function automatic logic [31:0] exp_read(input logic [11:0] a);
        for (int t = 0; t < 2; t++) begin
            if (a == base_of(t))         return m_cnt[t];
            if (a == base_of(t) + 12'd1) return {30'd0, m_ctl[t]};
            if (a == base_of(t) + 12'd2) return m_lim[t];
        end
        return 32'd0;
    endfunction

    task automatic model_reset();
        for (int t = 0; t < 2; t++) begin
            m_cnt[t] = '0; m_lim[t] = '1; m_ctl[t] = '0; m_pend[t] = 1'b0;
        end
    endtask

    task automatic model_step();
        for (int t = 0; t < 2; t++) begin
            logic cw, kw, lw, adv, hit;
            cw  = wr && (addr == base_of(t));
            kw  = wr && (addr == base_of(t) + 12'd1);
            lw  = wr && (addr == base_of(t) + 12'd2);
            adv = !m_ctl[t][1] || !halted;
            hit = adv && !cw && (m_cnt[t] == m_lim[t]);
            if (kw)                    m_pend[t] = 1'b0;
            else if (hit && m_ctl[t][0]) m_pend[t] = 1'b1;
            if (cw)       m_cnt[t] = wdata;
            else if (adv) m_cnt[t] = hit ? 32'd0 : m_cnt[t] + 32'd1;
            if (kw) m_ctl[t] = wdata[1:0];
            if (lw) m_lim[t] = wdata;
        end
    endtask

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, got, exp, $time);
        end
    endtask

    // Drive one cycle: inputs set after the falling edge, outputs compared before the rising edge.
    task automatic step(input logic w, input logic [11:0] a, input logic [31:0] d,
                        input logic h, input string tag);
        wr = w; addr = a; wdata = d; halted = h;
        #1;
        if (!w) chk(tag, rdata, exp_read(a));
        chk(tag, {30'd0, irq}, {30'd0, m_pend[1], m_pend[0]});
        @(posedge clk);
        model_step();
        @(negedge clk);
    endtask

    task automatic peek(input logic [11:0] a, input string tag, input logic [31:0] lit);
        wr = 1'b0; addr = a; #1;
        chk(tag, rdata, lit);
        @(negedge clk);
        model_step();
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        model_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset values (literal)
        wr = 0; addr = 12'h021; #1; chk("R1 cnt0", rdata, 32'd0);
        addr = 12'h023; #0.2; chk("R1 lim0", rdata, 32'hFFFFFFFF);
        addr = 12'h102; #0.2; chk("R1 lim1", rdata, 32'hFFFFFFFF);
        addr = 12'h101; #0.2; chk("R1 ctl1", rdata, 32'd0);
        chk("R1 irq", {30'd0, irq}, 32'd0);
        @(posedge clk); model_step(); @(negedge clk);

        // R2: control read masks upper bits
        step(1, 12'h022, 32'hFFFFFFFF, 0, "R2");
        peek(12'h022, "R2 ctl0", 32'd3);
        step(1, 12'h022, 32'd0, 0, "R2");
        step(0, 12'h022, 0, 0, "R2");

        // R3/R4: limit 5 with interrupt enabled
        step(1, 12'h023, 32'd5, 0, "R3");
        step(1, 12'h022, 32'd1, 0, "R4");
        step(1, 12'h021, 32'd0, 0, "R3");
        for (int k = 0; k < 10; k++) step(0, 12'h021, 0, 0, "R3");
        chk("R4 irq0", {31'd0, irq[0]}, 32'd1);
        step(0, 12'h021, 0, 0, "R4");

        // R5: acknowledge with arbitrary data
        step(1, 12'h022, 32'hFFFFFFFC, 0, "R5");
        chk("R5 ack", {31'd0, irq[0]}, 32'd0);
        // R5: ack in the same cycle as a hit
        step(1, 12'h023, 32'd3, 0, "R5");
        step(1, 12'h021, 32'd0, 0, "R5");
        step(1, 12'h022, 32'd1, 0, "R5");   // count 0 -> 1
        step(0, 12'h021, 0, 0, "R5");       // 1 -> 2
        step(0, 12'h021, 0, 0, "R5");       // 2 -> 3
        step(1, 12'h022, 32'd1, 0, "R5");   // count==3: hit and ack together
        chk("R5 race", {31'd0, irq[0]}, 32'd0);
        step(0, 12'h021, 0, 0, "R5");

        // R7: count write wins over wrap
        step(1, 12'h021, 32'd0, 0, "R7");
        step(0, 12'h021, 0, 0, "R7");
        step(0, 12'h021, 0, 0, "R7");
        step(0, 12'h021, 0, 0, "R7");       // count now 3 == limit
        step(1, 12'h021, 32'd77, 0, "R7");
        peek(12'h021, "R7 load", 32'd77);
        chk("R7 no irq", {31'd0, irq[0]}, 32'd0);

        // R6: gating on timer 1
        step(1, 12'h101, 32'd2, 0, "R6");
        step(1, 12'h100, 32'd40, 1, "R6");
        for (int k = 0; k < 4; k++) step(0, 12'h100, 0, 1, "R6");
        peek(12'h100, "R6 hold", 32'd40);
        step(1, 12'h101, 32'd0, 1, "R6");
        for (int k = 0; k < 3; k++) step(0, 12'h100, 0, 1, "R6");

        // R10: free-running wrap, no interrupt
        step(1, 12'h100, 32'hFFFFFFFD, 0, "R10");
        for (int k = 0; k < 5; k++) step(0, 12'h100, 0, 0, "R10");
        chk("R10 irq1", {31'd0, irq[1]}, 32'd0);

        // R8: unmapped addresses
        step(1, 12'h024, 32'hFFFFFFFF, 0, "R8");
        step(1, 12'h103, 32'hFFFFFFFF, 0, "R8");
        step(1, 12'h020, 32'hFFFFFFFF, 0, "R8");
        step(1, 12'h0FF, 32'hFFFFFFFF, 0, "R8");
        peek(12'h024, "R8 rd", 32'd0);
        step(0, 12'h023, 0, 0, "R8");
        step(0, 12'h102, 0, 0, "R8");
        step(0, 12'h101, 0, 0, "R8");

        // R9: mixed random traffic on both timers
        for (int k = 0; k < 4000; k++) begin
            logic [11:0] a;
            logic [31:0] d;
            int sel;
            sel = int'($urandom % 11);
            case (sel)
                0: a = 12'h021; 1: a = 12'h022; 2: a = 12'h023;
                3: a = 12'h100; 4: a = 12'h101; 5: a = 12'h102;
                6: a = 12'h020; 7: a = 12'h024; 8: a = 12'h0FF; 9: a = 12'h103;
                default: a = 12'($urandom);
            endcase
            if (a == 12'h022 || a == 12'h101) d = $urandom;
            else                              d = $urandom % 24;
            step(($urandom % 5) == 0, a, d, $urandom % 2, "R9");
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule